// File: doc/BRIEF.md
# Serial Mode-3 Register Access Port

This block lets an external serial master read and write a bank of 64 byte-wide registers held elsewhere on the chip. The master lowers chip select and sends one command byte, then one or more data bytes. The command byte chooses the direction and the starting register. Each data byte after it either writes a register or returns a register's value. Holding chip select low continues the transfer as a burst over consecutive registers.

The serial pins are sampled by the local system clock through a synchronizer. Serial clock edges are found as changes of the synchronized level. For this reason the serial clock must be several times slower than the system clock. On the register side the block drives an address, write data, a one-cycle write strobe and a one-cycle read strobe. The register bank must present the read data combinationally while the read strobe is high. The serial output comes with an enable, so a pad or the chip top can put it in high impedance.

Top module: `spi_regif`

## Requirements
- R1: After reset `dout_oe`, `reg_we` and `reg_re` are low.
- R2: The serial clock idles high. Input bits are sampled on its rising edge, MSB first, 8 bits per byte. The first byte after `cs_n` falls is the command: bit 7 is the direction (1 = read, 0 = write), bits 6..1 are the register address and bit 0 must be 1.
- R3: In a write, each completed data byte gives exactly one `reg_we` pulse of one clock. During that pulse `reg_wdata` holds the byte and `reg_addr` holds its register address.
- R4: In a burst write the address rises by one per data byte and wraps from 63 to 0.
- R5: In a read, `reg_re` pulses for one clock with the command's address once the eighth command bit has been taken. From the next serial clock falling edge on, `dout` carries that value MSB first and changes only after falling edges.
- R6: In a burst read the next register is fetched after the falling edge that puts out the last bit of the current byte. Its address is one higher and wraps from 63 to 0.
- R7: `dout_oe` is low while `cs_n` is high, during the command byte, and throughout write transactions.
- R8: A command byte whose bit 0 is 0 is ignored. No strobe fires and `dout_oe` stays low until `cs_n` rises.
- R9: A rise of `cs_n` at any point ends the transaction. A partly received byte is dropped without a write, and the next transaction starts again with a command byte.
- R10: `reg_we` and `reg_re` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data to the master |
| dout_oe | output | 1 | Drive enable for `dout` |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register read data, valid while `reg_re` is high |

## Verification
The bench builds the block with the default two-stage synchronizer. It drives the serial clock with a half period of eight system clocks, which leaves room for the detect latency and the one-clock fetch before the next falling edge. Since the address space has 64 registers, a three-byte burst from register 62 reaches the wrap to 0 in both directions. A behavioural register bank and a per-clock monitor check strobes, addresses and the output enable against the bench's own expected transactions.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_SKIP = 2'd3
    } xfer_state_t;

    // Command byte layout: direction, address, marker bit
    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic              marker;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        return cmd_t'(b);
    endfunction

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_regif_engine.sv
module spi_regif_engine
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_hi,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_bit,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              dout,
    output logic              dout_oe
);
    xfer_state_t       state;
    logic [CNT_W-1:0]  rcnt, fcnt;
    logic [BYTE_W-1:0] rx_sr, rx_next, tx_sr, wdata_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q, re_q, dout_q, oe_q;
    cmd_t              cmd_w;

    always_comb begin
        rx_next = {rx_sr[BYTE_W-2:0], din_bit};
        cmd_w   = decode_cmd(rx_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_CMD;
            rcnt    <= '0;
            fcnt    <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            wdata_q <= '0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            re_q    <= 1'b0;
            dout_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            re_q <= 1'b0;
            if (we_q) addr_q <= addr_q + 1'b1;
            if (re_q) tx_sr  <= reg_rdata;
            if (cs_hi) begin
                state <= ST_CMD;
                rcnt  <= '0;
                fcnt  <= '0;
                oe_q  <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    rx_sr <= rx_next;
                    rcnt  <= rcnt + 1'b1;
                    if (rcnt == CNT_W'(BYTE_W - 1)) begin
                        case (state)
                            ST_CMD: begin
                                if (!cmd_w.marker) begin
                                    state <= ST_SKIP;
                                end else begin
                                    addr_q <= cmd_w.addr;
                                    fcnt   <= '0;
                                    if (cmd_w.is_read) begin
                                        state <= ST_RD;
                                        re_q  <= 1'b1;
                                    end else begin
                                        state <= ST_WR;
                                    end
                                end
                            end
                            ST_WR: begin
                                wdata_q <= rx_next;
                                we_q    <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                if (sclk_fall && state == ST_RD) begin
                    dout_q <= tx_sr[BYTE_W-1];
                    tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                    oe_q   <= 1'b1;
                    fcnt   <= fcnt + 1'b1;
                    if (fcnt == CNT_W'(BYTE_W - 1)) begin
                        addr_q <= addr_q + 1'b1;
                        re_q   <= 1'b1;
                    end
                end
            end
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign reg_re    = re_q;
    assign dout      = dout_q;
    assign dout_oe   = oe_q;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(we_q && re_q));
    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        we_q |=> !we_q);
    // R7
    oe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> !oe_q);
    // R7
    oe_read_only_chk: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> state == ST_RD);
    // R4
    wr_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        we_q |=> addr_q == $past(addr_q) + 1'b1);
    // R8
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_SKIP |-> !re_q && !we_q && !oe_q);
endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic [2:0] pins_s;
    logic       sclk_q;

    spi_regif_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({cs_n, sclk, din}),
        .q  (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= pins_s[1];
    end

    spi_regif_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .cs_hi    (pins_s[2]),
        .sclk_rise(pins_s[1] & ~sclk_q),
        .sclk_fall(~pins_s[1] & sclk_q),
        .din_bit  (pins_s[0]),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );
endmodule

// File: tb/spi_regif_test.sv
module spi_regif_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic dout, dout_oe, reg_we, reg_re;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    always #5 clk = ~clk;

    spi_regif uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    // Behavioural register bank and bench-side expectation
    logic [7:0] bank    [64];
    logic [7:0] exp_mem [64];
    logic [13:0] wq[$];
    int checks = 0, fails = 0;
    int bad_oe = 0, bad_re = 0, both = 0, stray_we = 0;
    bit oe_ok = 0, re_ok = 0, done = 0;

    assign reg_rdata = bank[reg_addr];

    always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock monitor against the bench's expected traffic
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_we && reg_re) both++;
            if (dout_oe && !oe_ok) bad_oe++;
            if (reg_re && !re_ok) bad_re++;
            if (reg_we) begin
                if (wq.size() == 0) stray_we++;
                else begin
                    automatic logic [13:0] e = wq.pop_front();
                    check({reg_addr, reg_wdata} == e, "R3 write strobe addr/data",
                          {reg_addr, reg_wdata}, e);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx, output bit oe_all);
        rx = '0;
        oe_all = 1;
        for (int i = 7; i > 7 - n; i--) begin
            sclk = 1'b0;
            din  = tx[i];
            wait_clk(HALF);
            rx[i] = dout;
            if (!dout_oe) oe_all = 0;
            sclk = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic start();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic stop();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(6);
        oe_ok = 0;
        re_ok = 0;
        wait_clk(HALF);
    endtask

    task automatic do_write(input int a, input int n, input logic [7:0] d0, input logic [7:0] step);
        logic [7:0] rx;
        bit oe;
        start();
        bits({1'b0, 6'(a), 1'b1}, 8, rx, oe);
        for (int k = 0; k < n; k++) begin
            automatic logic [7:0] v = d0 + 8'(k) * step;
            automatic int ad = (a + k) & 63;
            wq.push_back({6'(ad), v});
            exp_mem[ad] = v;
            bits(v, 8, rx, oe);
        end
        stop();
        check(wq.size() == 0, "R4 all burst writes strobed", wq.size(), 0);
    endtask

    task automatic do_read(input int a, input int n, input string req);
        logic [7:0] rx;
        bit oe;
        re_ok = 1;
        start();
        bits({1'b1, 6'(a), 1'b1}, 8, rx, oe);
        oe_ok = 1;
        for (int k = 0; k < n; k++) begin
            automatic int ad = (a + k) & 63;
            bits(8'h00, 8, rx, oe);
            check(rx == exp_mem[ad], req, rx, exp_mem[ad]);
            check(oe, "R5 dout_oe high during read data", oe, 1);
        end
        stop();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        logic [7:0] rx;
        bit oe;
        int pre_re;
        for (int i = 0; i < 64; i++) begin
            bank[i]    = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);
        // R1 reset state
        check(!dout_oe, "R1 dout_oe after reset", dout_oe, 0);
        check(!reg_we, "R1 reg_we after reset", reg_we, 0);
        check(!reg_re, "R1 reg_re after reset", reg_re, 0);

        // R2 R3 single write, then read back (R5)
        do_write(5, 1, 8'hA5, 8'h00);
        do_read(5, 1, "R5 single read");

        // R4 burst write across the wrap, R6 burst read across the wrap
        do_write(62, 3, 8'h11, 8'h11);
        do_read(62, 3, "R6 burst read wrap");
        do_write(10, 4, 8'h3C, 8'h87);
        do_read(10, 4, "R6 burst read");
        do_read(40, 2, "R5 read untouched registers");

        // R9 partial write byte dropped
        start();
        bits({1'b0, 6'd20, 1'b1}, 8, rx, oe);
        wq.push_back({6'd20, 8'h77});
        exp_mem[20] = 8'h77;
        bits(8'h77, 8, rx, oe);
        bits(8'hE0, 3, rx, oe);
        stop();
        check(wq.size() == 0, "R9 full byte before abort written", wq.size(), 0);
        do_read(20, 2, "R9 partial byte not written");

        // R8 command with marker bit 0 ignored
        pre_re = bad_re;
        start();
        bits({1'b1, 6'd3, 1'b0}, 8, rx, oe);
        bits(8'hFF, 8, rx, oe);
        check(!oe, "R8 no drive after bad command", oe, 0);
        stop();
        check(bad_re == pre_re, "R8 no read strobe after bad command", bad_re - pre_re, 0);
        do_read(3, 1, "R8 next transaction starts fresh");

        // R9 abort inside the command byte, then a normal write
        start();
        bits(8'hFF, 4, rx, oe);
        stop();
        do_write(33, 1, 8'hC9, 8'h00);
        do_read(33, 1, "R9 fresh command after aborted command");

        check(bad_oe == 0, "R7 dout_oe only during read data", bad_oe, 0);
        check(bad_re == 0, "R8 read strobe only in reads", bad_re, 0);
        check(both == 0, "R10 strobes exclusive", both, 0);
        check(stray_we == 0, "R3 no unexpected write strobe", stray_we, 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end
endmodule